// File: doc/BRIEF.md
# Periodic Interval Tick Timer

The block divides the system clock by a fixed power of two and uses the result to advance an interval counter. The counter restarts from zero each time it reaches a programmed period. Every completed period raises a pending flag and bumps a period counter. Software can read two views of the same two counts. One view is a snapshot that leaves the flag and the period counter alone. The other is an acknowledging view that clears them. A level interrupt is raised while the flag is pending and interrupts are enabled.

A small register port, with a 2-bit register select, a write strobe and a read strobe, reaches four registers:

- The control register (select 0) holds the period and two enable bits.
- The status register (select 1) shows the pending flag.
- The acknowledging count register (select 2) returns both counts.
- The snapshot register (select 3) returns both counts without side effects.

Read data is combinational from the select. An acknowledge takes effect at the clock edge on which the read strobe is high with select 2.

Top module: `tick_interval_timer`

## Requirements
- R1: While running, the interval count advances by one every 16 clock cycles. After the run bit is set, the first advance lands on the 16th rising edge.
- R2: On an advance that would make the interval count reach or pass the period, the count returns to zero instead and one period elapses. A period of 0 behaves like a period of 1.
- R3: Each elapsed period sets the pending flag and adds one to a 12-bit period counter. The period counter wraps from 4095 to 0 without any other effect.
- R4: Select 2 returns the period counter in bits 31:20 and the interval count in bits 19:0. A read strobe on select 2 clears the pending flag and the period counter at that edge.
- R5: Select 3 returns the same fields in the same positions. Reading it changes neither the pending flag nor the period counter.
- R6: Select 0 is written in one access and reads back the same layout: the period in bits 19:0, the run bit in bit 24 and the interrupt enable in bit 25. All other bits read as zero.
- R7: The interrupt output is high exactly while the pending flag and the interrupt enable are both set. Once high, it stays high until an acknowledging read.
- R8: When a period elapses on the same edge as an acknowledging read, the period counter becomes 1 and the pending flag stays set.
- R9: Clearing the run bit holds the prescaler and the interval count at zero. The pending flag and the period counter keep their values.
- R10: Select 1 returns the pending flag in bit 0 and zeros in all other bits.
- R11: After reset, every register reads zero and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe; writes the control register when select is 0 |
| rd_en | input | 1 | Read strobe; acknowledges when select is 2 |
| addr | input | 2 | Register select |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the selected register |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach from the ports is an acknowledging read that lands on the very edge where a period elapses. The bench counts edges from the enabling write. It sets a short period and issues the acknowledging read so that its edge is exactly the 32nd. It then checks that the period counter restarts at 1 rather than 0. Silent wrap of the period counter is reached by running with the shortest period for 4096 periods. A table of periods and wait lengths covers general counting, and every expected count comes from an edge-count formula.

// File: rtl/tick_timer_pkg.sv
// Shared register selects and control-word bit positions for the tick timer.
// Assumes a 32-bit data path with counts packed as {period count, interval}.
package tick_timer_pkg;

    typedef enum logic [1:0] {
        REG_MODE   = 2'd0,
        REG_STATUS = 2'd1,
        REG_VALUE  = 2'd2,
        REG_IMAGE  = 2'd3
    } reg_sel_e;

    localparam int BUS_W   = 32;
    localparam int RUN_BIT = 24;
    localparam int IEN_BIT = 25;

endpackage

// File: rtl/tick_prescaler.sv
// Fixed power-of-two clock divider producing a one-cycle strobe.
// Assumes run_i is registered; the divider is held at zero while run_i is low.
module tick_prescaler #(
    parameter int PRE_LOG2 = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic strobe_o
);

    generate
        if (PRE_LOG2 == 0) begin : g_bypass
            // No division: every running cycle is a strobe.
            assign strobe_o = run_i;
        end else begin : g_divide
            logic [PRE_LOG2-1:0] div_q;

            // Free-running divider, cleared while stopped.
            always_ff @(posedge clk) begin
                if (!rst_n || !run_i) div_q <= '0;
                else                  div_q <= div_q + 1'b1;
            end

            assign strobe_o = run_i && (&div_q);

            p_strobe_sparse_r1: assert property (@(posedge clk) disable iff (!rst_n)
                strobe_o |=> !strobe_o);
        end
    endgenerate

endmodule

// File: rtl/tick_interval_counter.sv
// Interval counter: advances on each prescaler strobe and wraps at the period.
// Assumes period_i is stable between writes; a period of 0 acts like 1.
module tick_interval_counter #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] count_o,
    output logic             elapse_o
);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W:0]   next_w;
    logic             wrap_w;

    assign next_w   = {1'b0, count_q} + 1'b1;
    assign wrap_w   = tick_i && (next_w >= {1'b0, period_i});
    assign elapse_o = wrap_w;
    assign count_o  = count_q;

    // Count strobes; restart at the period; clear while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)       count_q <= '0;
        else if (!run_i)  count_q <= '0;
        else if (wrap_w)  count_q <= '0;
        else if (tick_i)  count_q <= next_w[CNT_W-1:0];
    end

    p_hold_between_ticks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !tick_i) |=> (count_q == $past(count_q)));

    p_restart_after_elapse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        elapse_o |=> (count_q == '0));

    p_stopped_is_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (count_q == '0));

endmodule

// File: rtl/tick_period_tracker.sv
// Pending flag and elapsed-period counter with acknowledge handling.
// Assumes ack_i is a single-cycle read strobe; a coincident elapse wins over clearing.
module tick_period_tracker #(
    parameter int PCNT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack_i,
    input  logic              elapse_i,
    output logic              pending_o,
    output logic [PCNT_W-1:0] pcount_o
);

    logic              pending_q;
    logic [PCNT_W-1:0] pcount_q;

    // Track periods since last acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
            pcount_q  <= '0;
        end else if (ack_i && elapse_i) begin
            pending_q <= 1'b1;
            pcount_q  <= PCNT_W'(1);
        end else if (ack_i) begin
            pending_q <= 1'b0;
            pcount_q  <= '0;
        end else if (elapse_i) begin
            pending_q <= 1'b1;
            pcount_q  <= pcount_q + 1'b1;
        end
    end

    assign pending_o = pending_q;
    assign pcount_o  = pcount_q;

    p_step_on_elapse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (elapse_i && !ack_i) |=> (pending_q && pcount_q == PCNT_W'($past(pcount_q) + 1'b1)));

    p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !elapse_i) |=> (!pending_q && pcount_q == '0));

    p_idle_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_i && !elapse_i) |=> ($stable(pending_q) && $stable(pcount_q)));

    p_same_edge_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && elapse_i) |=> (pending_q && pcount_q == PCNT_W'(1)));

endmodule

// File: rtl/tick_interval_timer.sv
// Top of the periodic tick timer: control register, read mux and interrupt.
// Assumes CNT_W + PCNT_W equals the 32-bit bus and CNT_W stays below the run bit.
module tick_interval_timer #(
    parameter int CNT_W    = 20,
    parameter int PCNT_W   = 12,
    parameter int PRE_LOG2 = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [1:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        irq
);
    import tick_timer_pkg::*;

    localparam int CNT_HI = CNT_W + PCNT_W - 1;

    reg_sel_e          sel_w;
    logic [CNT_W-1:0]  period_q;
    logic              run_q;
    logic              ien_q;
    logic              strobe_w;
    logic              elapse_w;
    logic              ack_w;
    logic              mode_wr_w;
    logic              pending_w;
    logic [CNT_W-1:0]  count_w;
    logic [PCNT_W-1:0] pcount_w;
    logic              unused_wbits;

    assign sel_w        = reg_sel_e'(addr);
    assign ack_w        = rd_en && (sel_w == REG_VALUE);
    assign mode_wr_w    = wr_en && (sel_w == REG_MODE);
    assign unused_wbits = ^{wdata[31:IEN_BIT+1], wdata[RUN_BIT-1:CNT_W]};

    // Control register capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '0;
            run_q    <= 1'b0;
            ien_q    <= 1'b0;
        end else if (mode_wr_w) begin
            period_q <= wdata[CNT_W-1:0];
            run_q    <= wdata[RUN_BIT];
            ien_q    <= wdata[IEN_BIT];
        end
    end

    tick_prescaler #(.PRE_LOG2(PRE_LOG2)) i_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run_q),
        .strobe_o (strobe_w)
    );

    tick_interval_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run_q),
        .tick_i   (strobe_w),
        .period_i (period_q),
        .count_o  (count_w),
        .elapse_o (elapse_w)
    );

    tick_period_tracker #(.PCNT_W(PCNT_W)) i_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack_i     (ack_w),
        .elapse_i  (elapse_w),
        .pending_o (pending_w),
        .pcount_o  (pcount_w)
    );

    // Read mux, combinational from the select.
    always_comb begin
        rdata = '0;
        case (sel_w)
            REG_MODE: begin
                rdata[CNT_W-1:0] = period_q;
                rdata[RUN_BIT]   = run_q;
                rdata[IEN_BIT]   = ien_q;
            end
            REG_STATUS: rdata[0] = pending_w;
            default: begin
                rdata[CNT_W-1:0]    = count_w;
                rdata[CNT_HI:CNT_W] = pcount_w;
            end
        endcase
    end

    assign irq = pending_w && ien_q;

    p_irq_held_until_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack_w && !mode_wr_w) |=> irq);

endmodule

// File: tb/test_tick_interval_timer.sv
`timescale 1ns/100ps
module test_tick_interval_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    tick_interval_timer i_tick_interval_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    localparam int NV = 6;
    localparam int VP[NV] = '{3, 1, 0, 5, 100, 2};
    localparam int VN[NV] = '{100, 50, 40, 400, 1000, 33};

    function automatic logic [31:0] mk(input int p, input logic run, input logic ien);
        logic [31:0] w;
        w = '0;
        w[19:0] = p[19:0];
        w[24] = run;
        w[25] = ien;
        return w;
    endfunction

    function automatic int peff(input int p);
        return (p == 0) ? 1 : p;
    endfunction

    function automatic int nper(input int p, input int e);
        return e / (16 * peff(p));
    endfunction

    function automatic logic [31:0] cnts(input int pc, input int iv);
        logic [31:0] w;
        w[31:20] = pc[11:0];
        w[19:0]  = iv[19:0];
        return w;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        addr = 2'd0; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        addr = a; rd_en = 1'b1;
        #0.2 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [31:0] d);
        addr = a;
        #0.2 d = rdata;
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : stim
        logic [31:0] d;
        int p, n, e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        peek(2'd0, d); chk("R11 mode", d, 32'h0);
        peek(2'd1, d); chk("R11 status", d, 32'h0);
        peek(2'd2, d); chk("R11 value", d, 32'h0);
        @(negedge clk);
        peek(2'd3, d); chk("R11 image", d, 32'h0);
        chk("R11 irq", {31'b0, irq}, 32'h0);
        @(negedge clk);

        // R6: control readback with both enables in one write
        wr(mk(20'h12345, 1'b1, 1'b1));
        peek(2'd0, d); chk("R6 readback", d, mk(20'h12345, 1'b1, 1'b1));
        @(negedge clk);

        // Table walk: R1 R2 R3 R4 R5 R7 R10
        for (int v = 0; v < NV; v++) begin
            p = VP[v]; n = VN[v];
            wr(mk(p, 1'b0, 1'b1));
            rd(2'd2, d);
            wr(mk(p, 1'b1, 1'b1));
            waitn(n);
            e = n;
            chk("R7 irq level", {31'b0, irq}, {31'b0, nper(p, e) > 0});
            peek(2'd1, d); chk("R10 status", d, {31'b0, nper(p, e) > 0});
            rd(2'd3, d);
            chk("R1 R2 R3 image", d, cnts(nper(p, e), (e / 16) % peff(p)));
            e = n + 1;
            rd(2'd2, d);
            chk("R4 R5 value after image read", d, cnts(nper(p, e), (e / 16) % peff(p)));
            e = n + 2;
            peek(2'd3, d);
            chk("R4 count after ack", {20'b0, d[31:20]}, 32'(nper(p, e) - nper(p, n + 1)));
            @(negedge clk);
        end

        // R7 gating and R9 stop retention
        wr(mk(1, 1'b0, 1'b0));
        rd(2'd2, d);
        wr(mk(1, 1'b1, 1'b0));
        waitn(40);
        peek(2'd1, d); chk("R7 pending while masked", d, 32'h1);
        chk("R7 masked irq low", {31'b0, irq}, 32'h0);
        wr(mk(1, 1'b1, 1'b1));
        chk("R7 irq on enable", {31'b0, irq}, 32'h1);
        waitn(20);
        chk("R7 irq held", {31'b0, irq}, 32'h1);
        wr(mk(1, 1'b0, 1'b1));
        peek(2'd3, d); chk("R9 stop keeps count", d, cnts(3, 0));
        waitn(40);
        peek(2'd3, d); chk("R9 frozen while stopped", d, cnts(3, 0));
        peek(2'd1, d); chk("R9 pending kept", d, 32'h1);
        rd(2'd2, d); chk("R4 value read", d, cnts(3, 0));
        peek(2'd1, d); chk("R4 status cleared", d, 32'h0);
        chk("R7 irq cleared by ack", {31'b0, irq}, 32'h0);

        // R8: acknowledge on the same edge as an elapse (edge 32, period 2)
        wr(mk(2, 1'b1, 1'b1));
        waitn(31);
        rd(2'd2, d); chk("R8 value before edge", d, cnts(0, 1));
        peek(2'd3, d); chk("R8 count restarts at one", d, cnts(1, 0));
        peek(2'd1, d); chk("R8 pending kept", d, 32'h1);
        chk("R8 irq kept", {31'b0, irq}, 32'h1);
        @(negedge clk);

        // R3: silent wrap of the period counter
        wr(mk(1, 1'b0, 1'b0));
        rd(2'd2, d);
        wr(mk(1, 1'b1, 1'b0));
        waitn(4096 * 16);
        peek(2'd3, d); chk("R3 wrap to zero", d, cnts(0, 0));
        peek(2'd1, d); chk("R3 pending after wrap", d, 32'h1);
        waitn(16);
        peek(2'd3, d); chk("R3 count after wrap", d, cnts(1, 0));

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule